// File: doc/BRIEF.md
# Serial Flash Slave Front End with Hold

This block is the device-side serial front end of a flash-style memory. The host selects the device with an active-low select line and toggles a serial clock. Each transfer carries an instruction byte first, then a fixed number of address bytes, then payload bytes, all on one data-in line. The block assembles these bits into bytes. It reports each byte on a one-cycle pulse interface to the internal logic, and it shifts a byte supplied by that logic back out on one data-out line. The data-out line has its own output enable, which models the tri-state pad.

All pins are sampled by a faster system clock, and serial-clock edges are found by comparing each sample with the one before. Both idle polarities of the serial clock are accepted. An active-low pause input lets the host suspend a transfer in mid-byte. The pause takes effect only when the serial clock is low, or else at the next falling serial-clock edge. While paused, the shift state is frozen and the output is released. When the pause ends, the transfer carries on from the same bit. A mode input marks four-line transfers, and it disables the pause function.

Top module: `sflash_hold_frontend`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0, the pause is inactive, and the bit and byte counters restart. After reset no valid pulse is raised.
- R2: On each rising `sck` edge with the device selected and not paused, `sdi` is captured, most significant bit first. The first 8 captured bits after `cs_n` falls form the instruction, reported on a one-cycle `op_valid` pulse with `op_code`.
- R3: The next `ADDR_BYTES` bytes (3 by default) form the address, first byte in bits [23:16]. The address is reported on a one-cycle `addr_valid` pulse together with the last address byte.
- R4: Every later byte raises a one-cycle `wr_valid` pulse with `wr_byte`.
- R5: On the first falling `sck` edge after a byte completes, `tx_byte` is loaded, `tx_take` pulses and `sdo` shows its bit 7. Each further falling edge shifts in the next lower bit, then zeros. Before the first load of a transfer, `sdo` is 0.
- R6: Transfers that start and end with `sck` low (mode 0) and transfers that start and end with `sck` high (mode 3) both decode correctly. In mode 3, the falling edge before the first rising edge captures nothing.
- R7: With the device selected and `wide_mode` low, the pause begins in the cycle after a falling `hold_n` is sampled with `sck` low. If `hold_n` is low while `sck` is high, the pause begins after the next falling `sck` edge, and that edge is still processed.
- R8: The pause ends after a rising `hold_n` is sampled with `sck` low. If `hold_n` rises while `sck` is high, the pause ends after the next falling `sck` edge, and that edge is not processed.
- R9: While paused, `sdo_oe` is 0 and `sck` and `sdi` activity is ignored. After the pause the transfer resumes at the same bit, with the same output byte.
- R10: Raising `cs_n` during a pause clears the pause and the command state, so the next selection starts a fresh instruction.
- R11: While `wide_mode` is 1, `hold_n` has no effect and bytes keep being decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wide_mode | input | 1 | Four-line transfer in use; disables the pause |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| op_valid | output | 1 | Instruction byte pulse |
| op_code | output | WORD_W | Instruction byte |
| addr_valid | output | 1 | Address complete pulse |
| addr | output | WORD_W*ADDR_BYTES | Assembled address |
| wr_valid | output | 1 | Payload byte pulse |
| wr_byte | output | WORD_W | Payload byte |
| tx_byte | input | WORD_W | Byte to send next, from internal logic |
| tx_take | output | 1 | Pulse when `tx_byte` has been loaded |

## Verification
The byte pulses (`op_valid`, `addr_valid`, `wr_valid`) are high for exactly the one cycle after the system-clock edge that samples the eighth rising `sck` of a byte. `sdo` and `tx_take` change after the edge that samples the falling `sck`. The pause state changes after the edge that samples the qualifying `hold_n` or `sck` change. `sdo_oe` follows `cs_n` with no delay. The bench drives the pins at the falling system-clock edge, and a behavioural model advances at each rising edge. Every output is compared with the model at the next falling edge, so each result is checked in the cycle it is due. Directed checks also compare the decoded instruction, address and payload after mode 0, mode 3, both pause entry cases, deselection during a pause, and four-line mode.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

   typedef enum logic [1:0] {
      SEG_OPCODE  = 2'd0,
      SEG_ADDRESS = 2'd1,
      SEG_PAYLOAD = 2'd2
   } seg_e;

   // Which part of a transfer a byte index falls in.
   function automatic seg_e seg_of(input int unsigned idx, input int unsigned n_addr);
      if (idx == 0)
         return SEG_OPCODE;
      else if (idx <= n_addr)
         return SEG_ADDRESS;
      else
         return SEG_PAYLOAD;
   endfunction

endpackage

// File: rtl/sfh_edge_hold.sv
module sfh_edge_hold #(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic hold_n,
   input  logic wide_mode,
   output logic rise_ev,
   output logic fall_ev,
   output logic hold_active
);

   logic sck_q;
   logic hold_q;
   logic raw_rise;
   logic raw_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         hold_q <= 1'b1;
      end else begin
         sck_q  <= sck;
         hold_q <= hold_n;
      end
   end

   assign raw_rise = sck & ~sck_q;
   assign raw_fall = ~sck & sck_q;

   generate
      if (HOLD_EN) begin : g_hold
         logic hold_r;
         logic hold_edge;
         logic qualify;

         assign hold_edge = hold_n ^ hold_q;
         // the pause level is taken only while the clock is low
         assign qualify   = raw_fall | (hold_edge & ~sck);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_r <= 1'b0;
            else if (cs_n | wide_mode)
               hold_r <= 1'b0;
            else if (qualify)
               hold_r <= ~hold_n;
         end

         assign hold_active = hold_r;

         // R7
         hold_enter_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wide_mode && $fell(hold_n) && !sck) |=> hold_active);
         // R7
         hold_enter_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wide_mode && !hold_n && $fell(sck)) |=> hold_active);
         // R8
         hold_exit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wide_mode && hold_active && $rose(hold_n) && !sck) |=> !hold_active);
         // R11
         wide_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wide_mode |=> !hold_active);
      end else begin : g_nohold
         assign hold_active = 1'b0;
      end
   endgenerate

   assign rise_ev = raw_rise & ~cs_n & ~hold_active;
   assign fall_ev = raw_fall & ~cs_n & ~hold_active;

   // R9
   frozen_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> !(rise_ev || fall_ev));

endmodule

// File: rtl/sfh_rx_deser.sv
module sfh_rx_deser #(
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              sdi,
   output logic              last_bit,
   output logic              done,
   output logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  cnt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-2:0] sr;

   assign last_bit = shift_en & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         cnt  <= '0;
         done <= 1'b0;
         word <= '0;
      end else begin
         done <= 1'b0;
         if (clr) begin
            sr  <= '0;
            cnt <= '0;
         end else if (shift_en) begin
            sr <= (WORD_W-1)'({sr, sdi});
            if (cnt == LAST) begin
               cnt  <= '0;
               done <= 1'b1;
               word <= {sr, sdi};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2
   done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(shift_en));

endmodule

// File: rtl/sfh_tx_ser.sv
module sfh_tx_ser #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              arm,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] load_val,
   output logic              sdo,
   output logic              take
);

   logic [WORD_W-1:0] sr;
   logic              pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         pend <= 1'b0;
         take <= 1'b0;
      end else begin
         take <= 1'b0;
         if (clr) begin
            sr   <= '0;
            pend <= 1'b0;
         end else begin
            if (arm)
               pend <= 1'b1;
            if (shift_en) begin
               if (pend) begin
                  sr   <= load_val;
                  pend <= 1'b0;
                  take <= 1'b1;
               end else begin
                  sr <= {sr[WORD_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sdo = sr[WORD_W-1];

   // R5
   take_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(shift_en));

endmodule

// File: rtl/sflash_hold_frontend.sv
module sflash_hold_frontend
   import sfh_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int ADDR_BYTES = 3,
   parameter bit HOLD_EN    = 1'b1,
   localparam int ADDR_W    = WORD_W * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic              hold_n,
   input  logic              wide_mode,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              op_valid,
   output logic [WORD_W-1:0] op_code,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_valid,
   output logic [WORD_W-1:0] wr_byte,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              tx_take
);

   localparam int ACC_W = ADDR_W - WORD_W;
   localparam int IDX_W = $clog2(ADDR_BYTES + 2);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX      = IDX_W'(ADDR_BYTES + 1);
   localparam logic [IDX_W-1:0] LAST_ADDR_IDX = IDX_W'(ADDR_BYTES);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (ADDR_BYTES < 2) begin : g_bad_addr
         $error("ADDR_BYTES must be at least 2");
      end
   endgenerate

   logic              rise_ev;
   logic              fall_ev;
   logic              hold_active;
   logic              last_bit;
   logic              rx_done;
   logic [WORD_W-1:0] rx_word;
   logic [CNT_W-1:0]  rx_cnt;
   logic [IDX_W-1:0]  idx;
   logic [ACC_W-1:0]  acc;
   seg_e              seg;

   sfh_edge_hold #(.HOLD_EN(HOLD_EN)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .sck        (sck),
      .hold_n     (hold_n),
      .wide_mode  (wide_mode),
      .rise_ev    (rise_ev),
      .fall_ev    (fall_ev),
      .hold_active(hold_active)
   );

   sfh_rx_deser #(.WORD_W(WORD_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cs_n),
      .shift_en(rise_ev),
      .sdi     (sdi),
      .last_bit(last_bit),
      .done    (rx_done),
      .word    (rx_word),
      .cnt     (rx_cnt)
   );

   sfh_tx_ser #(.WORD_W(WORD_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cs_n),
      .arm     (last_bit),
      .shift_en(fall_ev),
      .load_val(tx_byte),
      .sdo     (sdo),
      .take    (tx_take)
   );

   // byte framing: instruction, address bytes, then payload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         acc <= '0;
      end else if (cs_n) begin
         idx <= '0;
         acc <= '0;
      end else if (rx_done) begin
         if (idx != LAST_IDX)
            idx <= idx + 1'b1;
         if (seg == SEG_ADDRESS)
            acc <= (acc << WORD_W) | ACC_W'(rx_word);
      end
   end

   assign seg        = seg_of(32'(idx), ADDR_BYTES);
   assign op_valid   = rx_done & (seg == SEG_OPCODE);
   assign addr_valid = rx_done & (seg == SEG_ADDRESS) & (idx == LAST_ADDR_IDX);
   assign wr_valid   = rx_done & (seg == SEG_PAYLOAD);
   assign op_code    = rx_word;
   assign wr_byte    = rx_word;
   assign addr       = {acc, rx_word};
   assign sdo_oe     = ~cs_n & ~hold_active;

   // R1
   desel_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !hold_active);
   // R1
   desel_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !(op_valid || addr_valid || wr_valid));
   // R4
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_valid, addr_valid, wr_valid}));
   // R9
   hold_freezes_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && !cs_n) |=> $stable(rx_cnt));

endmodule

// File: tb/sflash_hold_frontend_tb.sv
module sflash_hold_frontend_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        hold_n = 1'b1;
   logic        wide_mode = 1'b0;
   logic [7:0]  tx_byte = 8'h5A;
   logic        sdo, sdo_oe, op_valid, addr_valid, wr_valid, tx_take;
   logic [7:0]  op_code, wr_byte;
   logic [23:0] addr;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   sflash_hold_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .hold_n(hold_n), .wide_mode(wide_mode), .sdo(sdo), .sdo_oe(sdo_oe),
      .op_valid(op_valid), .op_code(op_code), .addr_valid(addr_valid),
      .addr(addr), .wr_valid(wr_valid), .wr_byte(wr_byte),
      .tx_byte(tx_byte), .tx_take(tx_take)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference model ----------------
   bit          m_prev_sck, m_prev_hold, m_hold, m_pend;
   bit          m_bits[$];
   int          m_nbytes;
   logic [7:0]  m_tx;
   logic [23:0] m_acc;
   bit          m_opv, m_adv, m_wrv, m_take;
   logic [7:0]  m_op, m_wr;
   logic [23:0] m_addr;

   always @(posedge clk) begin : model
      bit rise, fall, hedge;
      logic [7:0] b;
      m_opv = 0; m_adv = 0; m_wrv = 0; m_take = 0;
      if (!rst_n) begin
         m_prev_sck = 0; m_prev_hold = 1; m_hold = 0; m_pend = 0;
         m_bits.delete(); m_nbytes = 0; m_tx = 0; m_acc = 0;
      end else begin
         rise  = sck && !m_prev_sck;
         fall  = !sck && m_prev_sck;
         hedge = (hold_n != m_prev_hold);
         if (cs_n) begin
            m_hold = 0; m_pend = 0; m_bits.delete(); m_nbytes = 0;
            m_tx = 0; m_acc = 0;
         end else begin
            if (!m_hold) begin
               if (rise) begin
                  m_bits.push_back(sdi);
                  if (m_bits.size() == 8) begin
                     b = 0;
                     foreach (m_bits[i]) b = {b[6:0], m_bits[i]};
                     m_bits.delete();
                     if (m_nbytes == 0) begin
                        m_opv = 1; m_op = b;
                     end else if (m_nbytes <= 3) begin
                        m_acc = {m_acc[15:0], b};
                        if (m_nbytes == 3) begin m_adv = 1; m_addr = m_acc; end
                     end else begin
                        m_wrv = 1; m_wr = b;
                     end
                     m_nbytes++;
                     m_pend = 1;
                  end
               end
               if (fall) begin
                  if (m_pend) begin m_tx = tx_byte; m_pend = 0; m_take = 1; end
                  else m_tx = {m_tx[6:0], 1'b0};
               end
            end
            if (wide_mode) m_hold = 0;
            else if (fall || (hedge && !sck)) m_hold = !hold_n;
         end
         m_prev_sck  = sck;
         m_prev_hold = hold_n;
      end
   end

   // ---------------- checking ----------------
   logic [7:0]  last_op;
   logic [23:0] last_addr;
   logic [7:0]  wr_q[$];
   int          n_take = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      bit exp_oe;
      if (!rst_n) return;
      exp_oe = !cs_n && !m_hold;
      chk(sdo_oe === exp_oe, cs_n ? "R1" : "R9", "sdo_oe", 32'(sdo_oe), 32'(exp_oe));
      if (exp_oe) chk(sdo === m_tx[7], "R5", "sdo", 32'(sdo), 32'(m_tx[7]));
      chk(tx_take === m_take, "R5", "tx_take", 32'(tx_take), 32'(m_take));
      chk(op_valid === m_opv, "R2", "op_valid", 32'(op_valid), 32'(m_opv));
      if (m_opv) chk(op_code === m_op, "R2", "op_code", 32'(op_code), 32'(m_op));
      chk(addr_valid === m_adv, "R3", "addr_valid", 32'(addr_valid), 32'(m_adv));
      if (m_adv) chk(addr === m_addr, "R3", "addr", 32'(addr), 32'(m_addr));
      chk(wr_valid === m_wrv, "R4", "wr_valid", 32'(wr_valid), 32'(m_wrv));
      if (m_wrv) chk(wr_byte === m_wr, "R4", "wr_byte", 32'(wr_byte), 32'(m_wr));
      if (op_valid) last_op = op_code;
      if (addr_valid) last_addr = addr;
      if (wr_valid) wr_q.push_back(wr_byte);
      if (tx_take) n_take++;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   task automatic bit_out(input bit b);
      tx_byte = tx_byte + 8'h3B;
      sck = 0; sdi = b; step(2);
      sck = 1; step(2);
   endtask

   task automatic send(input logic [31:0] v, input int nb);
      for (int i = nb - 1; i >= 0; i--) bit_out(v[i]);
   endtask

   task automatic begin_xfer(input bit idle_high);
      sck = idle_high; step(2);
      cs_n = 0; step(2);
   endtask

   task automatic end_xfer(input bit idle_high);
      sck = idle_high; step(2);
      cs_n = 1; step(3);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int takes0;
      step(4);
      rst_n = 1; step(2);
      // R1 reset state
      chk(sdo_oe === 1'b0, "R1", "oe after reset", 32'(sdo_oe), 0);
      chk({op_valid, addr_valid, wr_valid} === 3'b000, "R1", "pulses after reset",
          32'({op_valid, addr_valid, wr_valid}), 0);

      // R2 R3 R4 R5: mode 0 transfer
      wr_q.delete();
      takes0 = n_take;
      begin_xfer(0);
      send(8'h03, 8); send(24'h123456, 24); send(8'hA5, 8); send(8'h3C, 8);
      end_xfer(0);
      chk(last_op === 8'h03, "R2", "mode0 opcode", 32'(last_op), 32'h03);
      chk(last_addr === 24'h123456, "R3", "mode0 address", 32'(last_addr), 32'h123456);
      chk(wr_q.size() == 2, "R4", "payload count", 32'(wr_q.size()), 2);
      if (wr_q.size() == 2) begin
         chk(wr_q[0] === 8'hA5, "R4", "payload 0", 32'(wr_q[0]), 32'hA5);
         chk(wr_q[1] === 8'h3C, "R4", "payload 1", 32'(wr_q[1]), 32'h3C);
      end
      chk(n_take - takes0 == 6, "R5", "loads per transfer", 32'(n_take - takes0), 6);

      // R6: mode 3 transfer
      wr_q.delete();
      begin_xfer(1);
      send(8'hAB, 8); send(24'h0F00F0, 24); send(8'h11, 8);
      end_xfer(1);
      chk(last_op === 8'hAB, "R6", "mode3 opcode", 32'(last_op), 32'hAB);
      chk(last_addr === 24'h0F00F0, "R6", "mode3 address", 32'(last_addr), 32'h0F00F0);
      chk(wr_q.size() == 1 && wr_q[0] === 8'h11, "R6", "mode3 payload",
          32'(wr_q.size()), 1);
      sck = 0; step(2);

      // R7 R8 R9: pause entered and left with sck low
      begin_xfer(0);
      send(8'h0B, 8); send(8'hC3, 8); send(3'b010, 3);
      sck = 0; sdi = 1; step(2);
      hold_n = 0; step(1);
      chk(sdo_oe === 1'b0, "R7", "pause entered, clock low", 32'(sdo_oe), 0);
      sck = 1; sdi = 0; step(2); sck = 0; step(2); sck = 1; step(2); sck = 0; step(2);
      chk(sdo_oe === 1'b0, "R9", "output released in pause", 32'(sdo_oe), 0);
      hold_n = 1; step(1);
      chk(sdo_oe === 1'b1, "R8", "pause left, clock low", 32'(sdo_oe), 1);
      send(5'b11010, 5); send(8'h7E, 8);
      end_xfer(0);
      chk(last_addr === 24'hC35A7E, "R9", "address across pause", 32'(last_addr), 32'hC35A7E);

      // R7 R8 R9: pause requested and released with sck high
      wr_q.delete();
      begin_xfer(0);
      send(8'h02, 8); send(24'h000100, 24); send(3'b100, 3);
      hold_n = 0; step(2);
      chk(sdo_oe === 1'b1, "R7", "not paused while clock high", 32'(sdo_oe), 1);
      sck = 0; sdi = 1; step(2);
      chk(sdo_oe === 1'b0, "R7", "paused after falling clock", 32'(sdo_oe), 0);
      sck = 1; sdi = 0; step(2); sck = 0; step(2); sck = 1; step(2);
      hold_n = 1; step(2);
      chk(sdo_oe === 1'b0, "R8", "still paused until falling clock", 32'(sdo_oe), 0);
      sck = 0; step(2);
      chk(sdo_oe === 1'b1, "R8", "released after falling clock", 32'(sdo_oe), 1);
      send(5'b10110, 5);
      end_xfer(0);
      chk(wr_q.size() == 1 && wr_q[0] === 8'h96, "R9", "payload across pause",
          32'(wr_q.size() == 1 ? wr_q[0] : 8'h00), 32'h96);

      // R10: deselect during pause
      begin_xfer(0);
      send(8'h05, 8); send(4'b1011, 4);
      sck = 0; step(2);
      hold_n = 0; step(2);
      cs_n = 1; step(2);
      chk(sdo_oe === 1'b0, "R10", "deselected in pause", 32'(sdo_oe), 0);
      hold_n = 1; step(2);
      begin_xfer(0);
      send(8'h9F, 8); send(24'hABCDEF, 24);
      end_xfer(0);
      chk(last_op === 8'h9F, "R10", "fresh opcode after deselect", 32'(last_op), 32'h9F);
      chk(last_addr === 24'hABCDEF, "R10", "fresh address", 32'(last_addr), 32'hABCDEF);

      // R11: four-line mode ignores the pause pin
      wide_mode = 1; step(2);
      begin_xfer(0);
      send(2'b00, 2);
      hold_n = 0;
      send(6'b111011, 6);
      chk(sdo_oe === 1'b1, "R11", "no pause in wide mode", 32'(sdo_oe), 1);
      send(24'h13579B, 24);
      end_xfer(0);
      chk(last_op === 8'h3B, "R11", "opcode in wide mode", 32'(last_op), 32'h3B);
      chk(last_addr === 24'h13579B, "R11", "address in wide mode", 32'(last_addr), 32'h13579B);
      hold_n = 1; wide_mode = 0; step(4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule